// File: doc/BRIEF.md
# Real-Time Clock Source Selector

This block produces the clock-enable that drives a real-time counter. It picks one of three timing references: a fast oscillator reduced by a fixed factor of 32, a slow external crystal, or a slow on-chip RC oscillator. Each reference arrives as a single-cycle tick on the block's sampling clock. The block forwards the ticks of the chosen reference as a registered enable pulse.

The 2-bit choice sits in a register on the backup reset. Software may commit to one reference per backup reset. After that, the choice is frozen, and any later attempt to change it only raises a sticky flag. A system reset does not touch the choice. A slow reference keeps pulsing through a system reset. The fast divided path is stopped and its counter cleared for the duration of that reset.

A small monitor watches the peripheral bus tick and the enable output. It raises a sticky error when two enable pulses occur without a bus tick between them, which means the bus clock is slower than the real-time clock.

Top module: `rtc_clk_sel`

## Requirements
- R1: The value of `sel_o` picks the reference: 2'b01 is the slow crystal (`ext_lo_tick`), 2'b10 is the slow RC (`int_lo_tick`), 2'b11 is the fast oscillator divided by 32. `rtc_ce` is high in the cycle after a tick of the chosen reference and low otherwise.
- R2: A write of a nonzero value while unlocked loads `sel_o` and sets `sel_locked`. From then on `sel_o` cannot change until the backup reset.
- R3: A write while `sel_locked` is high leaves `sel_o` unchanged and sets `wr_ignored`, which stays high until the backup reset. A write of 2'b00 while unlocked does not lock.
- R4: With a slow reference chosen, `rtc_ce` keeps following that reference's ticks while `sys_rst_n` is low.
- R5: With the divided fast reference chosen, `rtc_ce` stays low while `sys_rst_n` is low, and the divide counter restarts. After the choice, or after a system reset ends, the first pulse follows the 32nd `osc_hi_tick`.
- R6: The backup reset clears `sel_o`, `sel_locked`, `wr_ignored` and `rtc_ce`. The system reset leaves `sel_o`, `sel_locked` and `wr_ignored` unchanged.
- R7: While `sel_o` is 2'b00, `rtc_ce` stays low.
- R8: `ratio_err` rises one cycle after an `rtc_ce` pulse when no `pclk_tick` has been seen since the previous `rtc_ce` pulse. A `pclk_tick` in the same cycle as the later pulse counts as seen. `ratio_err` stays high until the system reset clears it.
- R9: A write presented while `sys_rst_n` is low has no effect on `sel_o`, `sel_locked` or `wr_ignored`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all ticks and registers |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| osc_hi_tick | input | 1 | One tick per fast oscillator period |
| ext_lo_tick | input | 1 | One tick per slow crystal period |
| int_lo_tick | input | 1 | One tick per slow RC period |
| pclk_tick | input | 1 | One tick per peripheral bus clock period |
| sel_wr_en | input | 1 | Write strobe for the source choice |
| sel_wr_data | input | 2 | Value to write into the source choice |
| sel_o | output | 2 | Current source choice |
| sel_locked | output | 1 | Source choice is frozen |
| wr_ignored | output | 1 | Sticky: a write arrived after locking |
| rtc_ce | output | 1 | Real-time clock enable pulse |
| ratio_err | output | 1 | Sticky: bus clock slower than the real-time clock |

## Verification
`rtc_ce` is registered, so it answers a tick one edge later. The driver therefore queues one expected enable value per cycle at the falling edge where it drives the tick. The monitor compares that value just after the following rising edge. A write is captured at the next rising edge, so register-state checks of `sel_o`, `sel_locked` and `wr_ignored` are made only after one extra idle cycle. `ratio_err` lags the offending pulse by one more edge, two after the tick, so it is read several idle cycles later.

// File: rtl/rtc_sel_pkg.sv
package rtc_sel_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF     = 2'b00,
        SRC_XTAL_LO = 2'b01,
        SRC_RC_LO   = 2'b10,
        SRC_HI_DIV  = 2'b11
    } rtc_src_e;

    typedef struct packed {
        rtc_src_e sel;
        logic     locked;
        logic     ignored;
    } lock_state_t;

    typedef struct packed {
        logic armed;
        logic seen;
        logic err;
    } mon_state_t;

endpackage

// File: rtl/rtc_src_lock.sv
module rtc_src_lock
    import rtc_sel_pkg::*;
(
    input  logic     clk,
    input  logic     bkp_rst_n,
    input  logic     sys_rst_n,
    input  logic     wr_en,
    input  rtc_src_e wr_sel,
    output rtc_src_e sel,
    output logic     locked,
    output logic     ignored
);

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the bus side is dead while the system reset holds
        if (wr_en && sys_rst_n) begin
            if (st_q.locked) begin
                st_d.ignored = 1'b1;
            end else begin
                st_d.sel = wr_sel;
                if (wr_sel != SRC_OFF) begin
                    st_d.locked = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n) begin
            st_q <= '{sel: SRC_OFF, locked: 1'b0, ignored: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel     = st_q.sel;
    assign locked  = st_q.locked;
    assign ignored = st_q.ignored;

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        st_q.locked |=> $stable(st_q.sel)); // R2
    AST_IGNORED_STICKY: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        st_q.ignored |=> st_q.ignored); // R3
    AST_NO_WRITE_IN_SYSRST: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        !sys_rst_n |=> ($stable(st_q.sel) && $stable(st_q.locked) && $stable(st_q.ignored))); // R9

endmodule

// File: rtl/rtc_hi_div.sv
module rtc_hi_div #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick_in,
    output logic pulse_o
);

    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    assign pulse_o = en && tick_in && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (en && tick_in) begin
            st_d.cnt = pulse_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.cnt)); // R5

endmodule

// File: rtl/rtc_ratio_mon.sv
module rtc_ratio_mon
    import rtc_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rtc_ce,
    input  logic bus_tick,
    output logic err
);

    mon_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.seen = st_q.seen | bus_tick;
        if (rtc_ce) begin
            if (st_q.armed && !(st_q.seen || bus_tick)) begin
                st_d.err = 1'b1;
            end
            st_d.armed = 1'b1;
            st_d.seen  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err); // R8

endmodule

// File: rtl/rtc_clk_sel.sv
module rtc_clk_sel
    import rtc_sel_pkg::*;
#(
    parameter int HI_DIV = 32
) (
    input  logic             clk,
    input  logic             bkp_rst_n,
    input  logic             sys_rst_n,
    input  logic             osc_hi_tick,
    input  logic             ext_lo_tick,
    input  logic             int_lo_tick,
    input  logic             pclk_tick,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    output logic [SEL_W-1:0] sel_o,
    output logic             sel_locked,
    output logic             wr_ignored,
    output logic             rtc_ce,
    output logic             ratio_err
);

    rtc_src_e sel;
    logic     hi_pulse;
    logic     div_rst_n;
    logic     ce_d, ce_q;

    // the divider is stopped by either reset
    assign div_rst_n = sys_rst_n & bkp_rst_n;

    rtc_src_lock u_lock (
        .clk       (clk),
        .bkp_rst_n (bkp_rst_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (sel_wr_en),
        .wr_sel    (rtc_src_e'(sel_wr_data)),
        .sel       (sel),
        .locked    (sel_locked),
        .ignored   (wr_ignored)
    );

    rtc_hi_div #(.DIV(HI_DIV)) u_div (
        .clk     (clk),
        .rst_n   (div_rst_n),
        .en      (sel == SRC_HI_DIV),
        .tick_in (osc_hi_tick),
        .pulse_o (hi_pulse)
    );

    always_comb begin
        case (sel)
            SRC_XTAL_LO: ce_d = ext_lo_tick;
            SRC_RC_LO:   ce_d = int_lo_tick;
            SRC_HI_DIV:  ce_d = hi_pulse & sys_rst_n;
            default:     ce_d = 1'b0;
        endcase
    end

    // output lives in the backup domain so slow sources survive system reset
    always_ff @(posedge clk or negedge bkp_rst_n) begin
        if (!bkp_rst_n) begin
            ce_q <= 1'b0;
        end else begin
            ce_q <= ce_d;
        end
    end

    rtc_ratio_mon u_mon (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .rtc_ce   (ce_q),
        .bus_tick (pclk_tick),
        .err      (ratio_err)
    );

    assign sel_o  = sel;
    assign rtc_ce = ce_q;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (sel == SRC_OFF) |=> !ce_q); // R7
    AST_HI_GATED: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!sys_rst_n && sel == SRC_HI_DIV) |=> !ce_q); // R5
    AST_XTAL_PASS: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (sel == SRC_XTAL_LO) |=> (ce_q == $past(ext_lo_tick))); // R4
    AST_RC_PASS: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (sel == SRC_RC_LO) |=> (ce_q == $past(int_lo_tick))); // R1

endmodule

// File: tb/rtc_clk_sel_tb.sv
module rtc_clk_sel_tb;

    logic       clk = 1'b0;
    logic       bkp_rst_n, sys_rst_n;
    logic       osc_hi_tick, ext_lo_tick, int_lo_tick, pclk_tick;
    logic       sel_wr_en;
    logic [1:0] sel_wr_data;
    logic [1:0] sel_o;
    logic       sel_locked, wr_ignored, rtc_ce, ratio_err;

    always #10 clk = ~clk;

    rtc_clk_sel u_dut (
        .clk         (clk),
        .bkp_rst_n   (bkp_rst_n),
        .sys_rst_n   (sys_rst_n),
        .osc_hi_tick (osc_hi_tick),
        .ext_lo_tick (ext_lo_tick),
        .int_lo_tick (int_lo_tick),
        .pclk_tick   (pclk_tick),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .sel_o       (sel_o),
        .sel_locked  (sel_locked),
        .wr_ignored  (wr_ignored),
        .rtc_ce      (rtc_ce),
        .ratio_err   (ratio_err)
    );

    typedef struct {
        bit    ce;
        string tag;
    } exp_t;

    exp_t       exp_q[$];
    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 0;
    logic [1:0] m_sel  = 2'b00;
    bit         m_lock = 0;
    bit         m_ign  = 0;
    int         m_cnt  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected enable value per queued cycle
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(e.tag, {31'd0, rtc_ce}, {31'd0, e.ce});
        end
    end

    // driver: one cycle of stimulus plus the predicted enable
    task automatic step(input string tag, input bit hs, input bit xl, input bit rl,
                        input bit pk, input bit we = 0, input logic [1:0] wd = 2'b00);
        exp_t e;
        @(negedge clk);
        osc_hi_tick = hs; ext_lo_tick = xl; int_lo_tick = rl; pclk_tick = pk;
        sel_wr_en = we; sel_wr_data = wd;
        e.tag = tag;
        if (!bkp_rst_n) e.ce = 0;
        else case (m_sel)
            2'b01:   e.ce = xl;
            2'b10:   e.ce = rl;
            2'b11:   e.ce = sys_rst_n && hs && (m_cnt == 31);
            default: e.ce = 0;
        endcase
        exp_q.push_back(e);
        if (!bkp_rst_n || !sys_rst_n) m_cnt = 0;
        else if (m_sel == 2'b11 && hs) m_cnt = (m_cnt == 31) ? 0 : m_cnt + 1;
        if (bkp_rst_n && sys_rst_n && we) begin
            if (m_lock) m_ign = 1;
            else begin
                m_sel = wd;
                if (wd != 2'b00) m_lock = 1;
            end
        end
    endtask

    task automatic set_rst(input bit b, input bit s);
        @(negedge clk);
        osc_hi_tick = 0; ext_lo_tick = 0; int_lo_tick = 0; pclk_tick = 1;
        sel_wr_en = 0;
        bkp_rst_n = b; sys_rst_n = s;
        if (!b) begin m_sel = 2'b00; m_lock = 0; m_ign = 0; end
        if (!b || !s) m_cnt = 0;
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " sel"},     {30'd0, sel_o},      {30'd0, m_sel});
        chk({tag, " locked"},  {31'd0, sel_locked}, {31'd0, m_lock});
        chk({tag, " ignored"}, {31'd0, wr_ignored}, {31'd0, m_ign});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bkp_rst_n = 0; sys_rst_n = 0;
        osc_hi_tick = 0; ext_lo_tick = 0; int_lo_tick = 0; pclk_tick = 0;
        sel_wr_en = 0; sel_wr_data = 2'b00;
        repeat (3) @(negedge clk);
        set_rst(1, 1);
        step("R6", 0, 0, 0, 1);
        // reset state
        check_regs("R6 reset");
        chk("R6 reset ce", {31'd0, rtc_ce}, 32'd0);
        chk("R8 reset err", {31'd0, ratio_err}, 32'd0);

        // no source: output quiet, writing 00 does not lock
        for (int i = 0; i < 4; i++) step("R7", 1, 1, 1, 1);
        step("R3", 0, 0, 0, 1, 1, 2'b00);
        step("R3", 0, 0, 0, 1);
        check_regs("R3 zero write");

        // write during system reset is dropped
        set_rst(1, 0);
        step("R9", 0, 1, 0, 1, 1, 2'b01);
        step("R9", 0, 1, 0, 1);
        check_regs("R9");
        set_rst(1, 1);

        // pick the slow crystal, lock
        step("R2", 0, 0, 0, 1, 1, 2'b01);
        step("R2", 0, 0, 0, 1);
        check_regs("R2 lock");
        for (int i = 0; i < 6; i++) step("R1", 0, i[0], !i[0], 1);
        chk("R8 no err", {31'd0, ratio_err}, 32'd0);

        // later write ignored, flag set
        step("R3", 0, 0, 0, 1, 1, 2'b10);
        step("R3", 0, 0, 1, 1);
        check_regs("R3 ignored");

        // slow source keeps running through system reset
        set_rst(1, 0);
        for (int i = 0; i < 5; i++) step("R4", 0, i[0], 1, 1);
        set_rst(1, 1);
        step("R6", 0, 0, 0, 1);
        check_regs("R6 sysrst keeps");

        // bus clock slower than the real-time enable
        step("R8", 0, 1, 0, 1);
        step("R8", 0, 1, 0, 0);
        step("R8", 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) step("R8", 0, 0, 0, 1);
        chk("R8 err set", {31'd0, ratio_err}, 32'd1);
        set_rst(1, 0);
        set_rst(1, 1);
        step("R8", 0, 0, 0, 1);
        chk("R8 err cleared", {31'd0, ratio_err}, 32'd0);

        // backup reset clears everything
        set_rst(0, 1);
        set_rst(1, 1);
        step("R6", 0, 0, 0, 1);
        check_regs("R6 bkp clear");

        // divided fast source
        step("R5", 0, 0, 0, 1, 1, 2'b11);
        for (int i = 0; i < 40; i++) step("R5", 1, 1, 1, 1);
        check_regs("R1 hi sel");
        set_rst(1, 0);
        for (int i = 0; i < 40; i++) step("R5", 1, 0, 0, 1);
        set_rst(1, 1);
        for (int i = 0; i < 34; i++) step("R5", 1, 0, 0, 1);
        for (int i = 0; i < 3; i++) step("R5", 0, 0, 0, 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule